// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches a synchronised serial receive line and reports a break: a stretch of low line level that lasts at least one whole character frame. It runs beside the character receiver and does not depend on it. It measures each low stretch from the falling edge to the next rising edge. When the line returns high, it emits a single-cycle pulse if the stretch was long enough. The receiver uses that pulse to drop whatever it was doing and go back to waiting for a start bit.

The length of a break is worked out from the configured character format and the bit time in clock cycles. The format sets the data width, whether a parity bit is present and the stop length in half bits. A polarity option flips the line before any edge is looked at, so lines that idle low are handled the same way as lines that idle high.

Top module: `uart_break_det`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `break_o` is 0. During reset the current (polarity-corrected) line level is taken as the reference for edge detection.
- R2: Every falling edge of the corrected line starts a new low-time measurement and discards any earlier partial one.
- R3: The threshold T in clock cycles is ceil(H × `cfg_bit_cycles` / 2), where H = 2 × (1 + `cfg_data_bits` + `cfg_parity_en`) + `cfg_stop_half`. `cfg_data_bits` takes the values 5 to 9. `cfg_stop_half` takes the values 0, 1, 2 and 3, meaning 0, 0.5, 1 and 1.5 stop bits.
- R4: When the corrected line rises after N consecutive low samples, `break_o` is high for exactly the one cycle after the rising sample if N ≥ T, and stays 0 if N < T.
- R5: `break_o` stays 0 while the line is still low, however long the low stretch lasts.
- R6: After each rising edge the measurement is cleared, whether or not a break was reported. A following short low stretch gives no pulse.
- R7: When `cfg_invert` is 1, the raw line is inverted before edge detection: a raw high stretch counts as low time.
- R8: The low-time count stops at its largest value instead of wrapping, so a stretch longer than the count range is still reported if T fits the range.
- R9: A rising edge with no falling edge seen since reset gives no pulse, even after a long low stretch held through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Synchronised serial line |
| cfg_invert | input | 1 | 1 = invert the line before edge detection |
| cfg_data_bits | input | 4 | Data bits per character, 5 to 9 |
| cfg_parity_en | input | 1 | 1 = one parity bit per character |
| cfg_stop_half | input | 2 | Stop length in half bits, 0 to 3 |
| cfg_bit_cycles | input | BIT_W | Bit time in clock cycles |
| break_o | output | 1 | One-cycle break pulse |

## Verification
The rising edge that closes a low stretch is also the cycle in which the count is compared against the threshold. The stretch length therefore decides the result at the exact boundary, and the bench drives low stretches of T−1 and T samples for several formats. A pulse must appear only for the second. The same comparison also falls on a count that has stopped at its largest value: with a narrowed counter, a stretch longer than the count range must still give a pulse, where a wrapped count would not.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2
    } edge_e;

    // Frame length in half-bit units: start, data, optional parity, stop.
    function automatic logic [5:0] frame_half_units(
        input logic [3:0] data_bits,
        input logic       parity_en,
        input logic [1:0] stop_half
    );
        logic [5:0] whole;
        whole = {2'b00, data_bits} + 6'd1 + {5'b00000, parity_en};
        return (whole << 1) + {4'b0000, stop_half};
    endfunction

endpackage

// File: rtl/brk_edge.sv
module brk_edge
    import brk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_raw,
    input  logic  invert,
    output edge_e ev
);
    logic level;
    logic level_q;

    assign level = line_raw ^ invert;

    // During reset the reference follows the line, so no edge is invented.
    always_ff @(posedge clk) begin
        level_q <= level;
    end

    always_comb begin
        if (rst)
            ev = EDGE_NONE;
        else if (level_q && !level)
            ev = EDGE_FALL;
        else if (!level_q && level)
            ev = EDGE_RISE;
        else
            ev = EDGE_NONE;
    end
endmodule

// File: rtl/brk_thresh.sv
module brk_thresh
    import brk_pkg::*;
#(
    parameter int BIT_W = 12,
    parameter int CNT_W = 16
) (
    input  logic [3:0]       data_bits,
    input  logic             parity_en,
    input  logic [1:0]       stop_half,
    input  logic [BIT_W-1:0] bit_cycles,
    output logic [CNT_W-1:0] thr
);
    localparam logic [63:0] LIMIT = {{(64-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [63:0] halves;
    logic [63:0] product;
    logic [63:0] rounded;

    always_comb begin
        halves  = 64'(frame_half_units(data_bits, parity_en, stop_half));
        product = halves * 64'(bit_cycles);
        rounded = (product + 64'd1) >> 1;
        if (rounded > LIMIT)
            thr = LIMIT[CNT_W-1:0];
        else
            thr = rounded[CNT_W-1:0];
    end
endmodule

// File: rtl/brk_interval.sv
module brk_interval
    import brk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_e            ev,
    input  logic [CNT_W-1:0] thr,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             armed;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            unique case (ev)
                EDGE_FALL: begin
                    armed <= 1'b1;
                    cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
                end
                EDGE_RISE: begin
                    pulse <= armed && (cnt >= thr);
                    armed <= 1'b0;
                    cnt   <= '0;
                end
                default: begin
                    if (armed && cnt != CNT_MAX)
                        cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R2: a falling edge restarts the measurement at one low sample
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (ev == EDGE_FALL) |=> (armed && cnt == 1));

    // R6: a rising edge always clears the tracking
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (ev == EDGE_RISE) |=> (!armed && cnt == 0));

    // R8: the count never wraps while it is running
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (armed && ev == EDGE_NONE) |=> (cnt >= $past(cnt)));

    // R9: no pulse can follow a cycle without a recorded fall
    a_r9_needs_fall: assert property (@(posedge clk) disable iff (rst)
        (!armed) |=> !pulse);
endmodule

// File: rtl/uart_break_det.sv
module uart_break_det
    import brk_pkg::*;
#(
    parameter int BIT_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             cfg_invert,
    input  logic [3:0]       cfg_data_bits,
    input  logic             cfg_parity_en,
    input  logic [1:0]       cfg_stop_half,
    input  logic [BIT_W-1:0] cfg_bit_cycles,
    output logic             break_o
);
    edge_e            ev;
    logic [CNT_W-1:0] thr;
    logic             level_now;

    assign level_now = line_in ^ cfg_invert;

    brk_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .line_raw (line_in),
        .invert   (cfg_invert),
        .ev       (ev)
    );

    brk_thresh #(
        .BIT_W (BIT_W),
        .CNT_W (CNT_W)
    ) u_thresh (
        .data_bits  (cfg_data_bits),
        .parity_en  (cfg_parity_en),
        .stop_half  (cfg_stop_half),
        .bit_cycles (cfg_bit_cycles),
        .thr        (thr)
    );

    brk_interval #(
        .CNT_W (CNT_W)
    ) u_interval (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .thr   (thr),
        .pulse (break_o)
    );

    // R4: the pulse lasts one cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
        break_o |=> !break_o);

    // R4, R5: a pulse follows a low sample and then a high sample
    a_r5_after_rise: assert property (@(posedge clk) disable iff (rst)
        break_o |-> ($past(level_now) && !$past(level_now, 2)));

    // R3: a non-zero bit time never gives a zero threshold
    a_r3_thr_nonzero: assert property (@(posedge clk) disable iff (rst)
        (cfg_bit_cycles != 0) |-> (thr != 0));

    // R1: pulse is low the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !break_o);
endmodule

// File: tb/sim_uart_break_det.sv
`timescale 1ns/1ps
module sim_uart_break_det;
    localparam int BIT_W = 12;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic [3:0]  db;
        logic        par;
        logic [1:0]  st;
        logic        inv;
        logic [11:0] bc;
        logic [11:0] len;
        logic        exp;
    } vec_t;

    // thresholds: 8/0/1.0 x4 -> 40 ; 5/0/0.5 x3 -> 20 ; 9/1/1.5 x2 -> 25 ;
    // 7/1/0 x5 -> 45 ; 7/0/0 x5 -> 40
    localparam vec_t VEC [10] = '{
        '{4'd8, 1'b0, 2'd2, 1'b0, 12'd4, 12'd39, 1'b0},
        '{4'd8, 1'b0, 2'd2, 1'b0, 12'd4, 12'd40, 1'b1},
        '{4'd5, 1'b0, 2'd1, 1'b0, 12'd3, 12'd19, 1'b0},
        '{4'd5, 1'b0, 2'd1, 1'b0, 12'd3, 12'd20, 1'b1},
        '{4'd9, 1'b1, 2'd3, 1'b1, 12'd2, 12'd24, 1'b0},
        '{4'd9, 1'b1, 2'd3, 1'b1, 12'd2, 12'd25, 1'b1},
        '{4'd7, 1'b1, 2'd0, 1'b0, 12'd5, 12'd44, 1'b0},
        '{4'd7, 1'b1, 2'd0, 1'b0, 12'd5, 12'd60, 1'b1},
        '{4'd8, 1'b0, 2'd2, 1'b1, 12'd4, 12'd41, 1'b1},
        '{4'd7, 1'b0, 2'd0, 1'b0, 12'd5, 12'd44, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_in = 1'b1;
    logic             cfg_invert = 1'b0;
    logic [3:0]       cfg_data_bits = 4'd8;
    logic             cfg_parity_en = 1'b0;
    logic [1:0]       cfg_stop_half = 2'd2;
    logic [BIT_W-1:0] cfg_bit_cycles = 12'd4;
    logic             break_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_break_det #(.BIT_W(BIT_W), .CNT_W(CNT_W)) u0 (
        .clk            (clk),
        .rst            (rst),
        .line_in        (line_in),
        .cfg_invert     (cfg_invert),
        .cfg_data_bits  (cfg_data_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_stop_half  (cfg_stop_half),
        .cfg_bit_cycles (cfg_bit_cycles),
        .break_o        (break_o)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: break_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic configure(input logic [3:0] db, input logic par,
                             input logic [1:0] st, input logic inv,
                             input logic [11:0] bc);
        @(negedge clk);
        cfg_data_bits  = db;
        cfg_parity_en  = par;
        cfg_stop_half  = st;
        cfg_invert     = inv;
        cfg_bit_cycles = bc;
        line_in        = ~inv;
        repeat (3) @(negedge clk);
    endtask

    // Holds the corrected line low for len samples, releases it and returns
    // at the negedge where a pulse would be visible. quiet=1 if no pulse
    // was seen during the low stretch.
    task automatic low_stretch(input int len, output logic seen, output logic quiet);
        quiet = 1'b1;
        line_in = cfg_invert;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (break_o) quiet = 1'b0;
        end
        line_in = ~cfg_invert;
        @(negedge clk);
        seen = break_o;
    endtask

    initial begin
        logic seen;
        logic quiet;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(break_o, 1'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(break_o, 1'b0, "R1 after reset");

        // Table walk: R3 thresholds, R4 boundaries, R7 inversion
        foreach (VEC[i]) begin
            configure(VEC[i].db, VEC[i].par, VEC[i].st, VEC[i].inv, VEC[i].bc);
            low_stretch(int'(VEC[i].len), seen, quiet);
            check(seen, VEC[i].exp, $sformatf("R3/R4/R7 vector %0d", i));
            check(quiet, 1'b1, $sformatf("R5 vector %0d", i));
            @(negedge clk);
            check(break_o, 1'b0, $sformatf("R4 one-cycle vector %0d", i));
        end

        // R2: falling edge restarts measurement (threshold 40)
        configure(4'd8, 1'b0, 2'd2, 1'b0, 12'd4);
        low_stretch(30, seen, quiet);
        check(seen, 1'b0, "R2 first part");
        @(negedge clk);
        low_stretch(30, seen, quiet);
        check(seen, 1'b0, "R2 restart after short high");

        // R6: tracking cleared after a reported break
        low_stretch(50, seen, quiet);
        check(seen, 1'b1, "R6 break reported");
        @(negedge clk);
        low_stretch(10, seen, quiet);
        check(seen, 1'b0, "R6 short stretch after break");

        // R8: saturation, threshold 20*12/2 = 120, count range 255
        configure(4'd8, 1'b0, 2'd2, 1'b0, 12'd12);
        low_stretch(300, seen, quiet);
        check(quiet, 1'b1, "R5 no pulse during long low");
        check(seen, 1'b1, "R8 long break past count range");

        // R9: line low through reset, no fall seen afterwards
        configure(4'd8, 1'b0, 2'd2, 1'b0, 12'd4);
        rst = 1'b1;
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        check(break_o, 1'b0, "R9 rise without fall");
        @(negedge clk);
        check(break_o, 1'b0, "R9 following cycle");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule